// File: doc/BRIEF.md
# Streaming Session Controller with Idle Timeout

This block is the control core of a streaming encrypt/decrypt engine. It owns the session flags (busy, input-ready, finish and output-valid) and leaves the cipher datapath out. A start pulse opens a session. Input-ready then stays low for a fixed setup interval, which stands for the initial tweak computation. After that, one data beat can be accepted on every clock under a valid/ready handshake. Each accepted beat comes out as an output-valid strobe after a fixed latency, which models the cipher pipeline.

The session closes by itself. When enough consecutive cycles go by without an accepted beat, and no output beat is still in flight, a one-cycle finish pulse is raised and busy drops on the next cycle. Input-ready stays high while the block is idle. A beat that arrives then reopens the session with no new start and no new setup, so the same key and the running tweak carry on. While the block is busy, start requests and requests to load the data key or the tweak key are refused. The key requests are granted with a combinational strobe only while the block is idle.

Top module: `stream_session_ctrl`

## Requirements
- R1: A start pulse while busy_o is 0 makes busy_o 1 and in_ready_o 0 on the next cycle.
- R2: After an accepted start, in_ready_o stays 0 for SETUP_CYC cycles and then returns to 1. While it is 1, a beat is accepted on every cycle that in_valid_i is 1.
- R3: in_valid_i has no effect while in_ready_o is 0. It produces no out_valid_o strobe and does not set busy_o.
- R4: A beat accepted while busy_o is 0 sets busy_o to 1 on the next cycle, with no start pulse and no setup interval.
- R5: out_valid_o is 1 exactly PIPE_LAT cycles after each accepted beat, and at no other time.
- R6: An idle cycle is a cycle in which busy_o is 1, in_ready_o is 1 and no beat is accepted. Accepted beats and starts reset the idle count. Once IDLE_LIMIT idle cycles have passed and no out_valid_o strobe is still pending, finish_o is 1 for exactly one cycle and busy_o is 0 on the cycle after it.
- R7: While busy_o is 1, start_i, dkey_req_i and tkey_req_i are ignored. dkey_grant_o and tkey_grant_o stay 0, and in_ready_o does not drop. While busy_o is 0, each grant equals its request.
- R8: After finish_o, in_ready_o is 1 and data can resume without a start pulse.
- R9: After reset, busy_o, finish_o and out_valid_o are 0 and in_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Session start pulse (new IV and mode) |
| dkey_req_i | input | 1 | Request to load the data key |
| tkey_req_i | input | 1 | Request to load the tweak key |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Controller can take an input beat |
| busy_o | output | 1 | Session active |
| finish_o | output | 1 | One-cycle pulse when the session closes |
| out_valid_o | output | 1 | Output beat valid |
| dkey_grant_o | output | 1 | Data key request accepted |
| tkey_grant_o | output | 1 | Tweak key request accepted |

## Verification
Busy and ready respond one cycle after a start or an accepted beat. out_valid_o follows PIPE_LAT cycles after the beat that caused it. finish_o appears in the IDLE_LIMIT+1-th cycle after the last accepted beat, and the grants follow their requests in the same cycle. The bench applies inputs just after the falling edge and samples one nanosecond later. By then both the registered outputs and the combinational ones (grants, finish) have settled for that cycle. A behavioural model advances once per cycle and keeps a queue of due cycles for output strobes. Every output is compared against this model on every cycle, and directed checks cover resume-without-start and the idle-count reset.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int unsigned DEF_SETUP_CYC  = 4;
  localparam int unsigned DEF_PIPE_LAT   = 3;
  localparam int unsigned DEF_IDLE_LIMIT = 16;
endpackage

// File: rtl/ssc_setup_timer.sv
module ssc_setup_timer #(
  parameter int unsigned SETUP_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(SETUP_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= CW'(SETUP_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == '0);

  AST_SETUP_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !ready_o); // R2
endmodule

// File: rtl/ssc_idle_monitor.sv
module ssc_idle_monitor #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] MAXV = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clear_i)                 cnt_q <= '0;
    else if (tick_i && cnt_q != MAXV) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == MAXV);

  AST_IDLE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAXV); // R6
endmodule

// File: rtl/ssc_lat_pipe.sv
module ssc_lat_pipe #(
  parameter int unsigned LAT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o,
  output logic empty_o
);
  logic [LAT-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q[0] <= 1'b0;
    else         sr_q[0] <= in_i;
  end

  for (genvar g = 1; g < LAT; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q[g] <= 1'b0;
      else         sr_q[g] <= sr_q[g-1];
    end
  end

  assign out_o   = sr_q[LAT-1];
  assign empty_o = ~|sr_q;

  AST_PIPE_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !in_i) |=> !out_o); // R5
endmodule

// File: rtl/stream_session_ctrl.sv
module stream_session_ctrl
  import ssc_pkg::*;
#(
  parameter int unsigned SETUP_CYC  = DEF_SETUP_CYC,
  parameter int unsigned PIPE_LAT   = DEF_PIPE_LAT,
  parameter int unsigned IDLE_LIMIT = DEF_IDLE_LIMIT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic dkey_req_i,
  input  logic tkey_req_i,
  input  logic in_valid_i,
  output logic in_ready_o,
  output logic busy_o,
  output logic finish_o,
  output logic out_valid_o,
  output logic dkey_grant_o,
  output logic tkey_grant_o
);
  logic busy_q;
  logic ready;
  logic start_ok;
  logic accept;
  logic idle_tick;
  logic expired;
  logic pipe_empty;
  logic finish;

  assign start_ok  = start_i & ~busy_q;
  assign accept    = in_valid_i & ready;
  assign idle_tick = busy_q & ready & ~accept;
  // close only once nothing is still in flight
  assign finish    = busy_q & expired & pipe_empty & ~accept;

  ssc_setup_timer #(.SETUP_CYC(SETUP_CYC)) u_setup (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_ok),
    .ready_o (ready)
  );

  ssc_idle_monitor #(.LIMIT(IDLE_LIMIT)) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start_ok | accept | finish),
    .tick_i    (idle_tick),
    .expired_o (expired)
  );

  ssc_lat_pipe #(.LAT(PIPE_LAT)) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .in_i    (accept),
    .out_o   (out_valid_o),
    .empty_o (pipe_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  busy_q <= 1'b0;
    else if (start_ok || accept)  busy_q <= 1'b1;
    else if (finish)              busy_q <= 1'b0;
  end

  assign busy_o       = busy_q;
  assign in_ready_o   = ready;
  assign finish_o     = finish;
  assign dkey_grant_o = dkey_req_i & ~busy_q;
  assign tkey_grant_o = tkey_req_i & ~busy_q;

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !in_ready_o)); // R1
  AST_BUSY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i || (in_valid_i && in_ready_o))); // R4
  AST_FINISH_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |=> (!busy_o && !finish_o)); // R6
  AST_RESUME_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |=> in_ready_o); // R8
  AST_BUSY_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && in_ready_o && start_i) |=> in_ready_o); // R7
endmodule

// File: tb/stream_session_ctrl_tb_top.sv
`timescale 1ns/1ps
module stream_session_ctrl_tb_top;
  localparam int SETUP = 4;
  localparam int LAT   = 3;
  localparam int IDLE  = 16;

  logic clk = 1'b0;
  logic rst_ni;
  logic start_i, dkey_req_i, tkey_req_i, in_valid_i;
  logic in_ready_o, busy_o, finish_o, out_valid_o, dkey_grant_o, tkey_grant_o;

  always #2 clk = ~clk;

  stream_session_ctrl #(.SETUP_CYC(SETUP), .PIPE_LAT(LAT), .IDLE_LIMIT(IDLE)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .dkey_req_i(dkey_req_i),
    .tkey_req_i(tkey_req_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .busy_o(busy_o), .finish_o(finish_o), .out_valid_o(out_valid_o),
    .dkey_grant_o(dkey_grant_o), .tkey_grant_o(tkey_grant_o)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // behavioural model state
  bit m_busy = 1'b0;
  int m_setup = 0;
  int m_idle = 0;
  int due_q[$];
  int cyc = 0;
  int n_acc = 0, n_ov = 0, n_fin = 0, exp_fin_cnt = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s cycle=%0d actual=%0d expected=%0d", tag, what, cyc, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic dk, input logic tk, input logic v);
    bit e_ready, acc, e_fin, e_ov, s_ok;
    @(negedge clk);
    start_i = s; dkey_req_i = dk; tkey_req_i = tk; in_valid_i = v;
    #1;
    e_ready = (m_setup == 0);
    acc     = v && e_ready;
    s_ok    = s && !m_busy;
    e_fin   = m_busy && (m_idle >= IDLE) && (due_q.size() == 0) && !acc;
    e_ov    = (due_q.size() > 0) && (due_q[0] == cyc);
    chk("R1", "busy_o", busy_o, m_busy);
    chk("R2", "in_ready_o", in_ready_o, e_ready);
    chk("R5", "out_valid_o", out_valid_o, e_ov);
    chk("R6", "finish_o", finish_o, e_fin);
    chk("R7", "dkey_grant_o", dkey_grant_o, dk && !m_busy);
    chk("R7", "tkey_grant_o", tkey_grant_o, tk && !m_busy);
    if (out_valid_o) n_ov++;
    if (finish_o) n_fin++;
    if (e_fin) exp_fin_cnt++;
    if (e_ov) void'(due_q.pop_front());
    if (acc) begin due_q.push_back(cyc + LAT); n_acc++; end
    if (s_ok || acc || e_fin) m_idle = 0;
    else if (m_busy && e_ready && m_idle < IDLE) m_idle++;
    if (s_ok) m_setup = SETUP;
    else if (m_setup > 0) m_setup--;
    if (s_ok || acc) m_busy = 1'b1;
    else if (e_fin) m_busy = 1'b0;
    cyc++;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; start_i = 0; dkey_req_i = 0; tkey_req_i = 0; in_valid_i = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R9", "reset busy_o", busy_o, 0);
    chk("R9", "reset in_ready_o", in_ready_o, 1);
    chk("R9", "reset finish_o", finish_o, 0);
    chk("R9", "reset out_valid_o", out_valid_o, 0);

    // keys while idle are granted
    step(0, 1, 1, 0);
    // start with valid held through setup: R3 valid ignored while not ready
    step(1, 0, 0, 1);
    for (int i = 0; i < SETUP; i++) step(0, 0, 0, 1);
    chk("R3", "beats accepted during setup", n_acc, 1);
    // continuous beats, then gaps, with refused start/key requests (R7)
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1);
    step(1, 1, 1, 0);
    step(0, 0, 0, 1);
    step(1, 0, 0, 1);
    idle_n(2);
    step(0, 0, 0, 1);
    // partial idle then a beat: idle count restarts
    idle_n(IDLE - 2);
    step(0, 0, 0, 1);
    idle_n(IDLE + 4);
    chk("R6", "finish pulses", n_fin, 1);
    chk("R3", "out strobes vs accepted beats", n_ov, n_acc);
    chk("R8", "ready after finish", in_ready_o, 1);
    // resume without start: R4
    step(0, 0, 0, 1);
    @(posedge clk); #1;
    chk("R4", "busy after idle beat", busy_o, 1);
    chk("R4", "no setup after idle beat", in_ready_o, 1);
    step(0, 0, 0, 1);
    idle_n(IDLE + 5);
    chk("R8", "second finish", n_fin, 2);
    // fresh start, back-to-back beats, finish exactly at limit
    step(1, 0, 0, 0);
    idle_n(SETUP);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1);
    idle_n(IDLE);
    chk("R6", "no finish before limit+1", n_fin, 2);
    step(0, 0, 0, 0);
    chk("R6", "finish at limit", n_fin, 3);
    idle_n(3);
    chk("R6", "finish count matches model", n_fin, exp_fin_cnt);
    chk("R5", "all outputs emitted", n_ov, n_acc);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule